// File: doc/BRIEF.md
# USB Link Power Control Register

This block is the 32-bit control word that sits beside a USB host/device protocol engine. It sequences the link's power states. Software reaches it through a plain write-strobe/read-data port. The stored bits drive the protocol engine reset, transceiver power-down, USB clock gating, the transceiver's low-power mode, start-of-frame generation in host mode, and resume signalling. No data stream passes through the block, so every pin is a plain level or strobe and there is no back-pressure to describe.

Suspend works as a request/acknowledge pair. Software raises the suspend-enable bit. Hardware answers with a read-only suspend-ready bit once no transaction is in flight. That acknowledge gates the clock and puts the transceiver into low power. A wakeup event arrives asynchronously and passes through a two-flop synchronizer. On its rising edge it raises a wakeup flag and, in the same cycle, drops both the request and the acknowledge.

The short (L1) resume bit launches a timed 50 µs pulse and then clears itself. The long (L2) resume bit drives resume for as long as software holds it. An idle timer raises a suspend indication after 3 ms without bus traffic. Ten mask bits select which status flags reach the single interrupt line. Both intervals are counted in clock cycles derived from a clock-frequency parameter.

Top module: `lpc_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x00000003: bit 0 (core reset) and bit 1 (power-down) are set and every other bit is 0. Bit 6 and bits 30..17 always read 0.
- R2: A write stores bits 0, 1, 3, 4, 16..7 and 31 from the write data. Written values to bit 2 (suspend-ready) and to the reserved bits are ignored.
- R3: `core_rst` follows bit 0. `host_bus_rst` is high only when bit 0 and bit 31 (host mode) are both set.
- R4: With bit 3 (suspend enable) set and `xact_busy` low, bit 2 becomes 1 one clock after the edge that set bit 3. `clk_gate_en` and `xcvr_lowpwr` follow bit 2. Writing bit 3 to 0 clears bit 2 on the same edge.
- R5: While `xact_busy` is high, bit 2 stays 0 even though bit 3 is set. Bit 2 is set on the first edge at which `xact_busy` is low.
- R6: `wake_async` is synchronized by two flops. The edge after the synchronized value rises sets `wake_flag` and clears bits 3 and 2 together. This clear wins over a write that sets bit 3 in that same cycle.
- R7: Writing bit 5 (L1 resume) as 1 while it is 0 holds bit 5 and `resume_drv` high for exactly CLK_MHZ*50 cycles, after which hardware clears bit 5. Writes to bit 5 while the pulse runs are ignored.
- R8: Bit 4 (L2 resume) drives `resume_drv` for as long as it is set. Clearing it in host mode re-enables `sof_en`.
- R9: After CLK_MHZ*3000 consecutive cycles with `bus_activity` low, `idle_flag` is set once. Any cycle with `bus_activity` high restarts the count.
- R10: `irq` is the OR over ten sources of flag AND mask. Mask bit 7+i enables source i. Source 4 is `idle_flag` and source 5 is `wake_flag`. Sources 0..3 are `ext_flags[3:0]` and sources 6..9 are `ext_flags[7:4]`.
- R11: `sof_en` is high only in host mode (bit 31) when bits 0, 1, 2, 3, 4 and 5 are all 0.
- R12: `xcvr_pdn` follows bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Current register contents |
| xact_busy | input | 1 | A bus transaction is in progress |
| bus_activity | input | 1 | Bus traffic seen this cycle |
| wake_async | input | 1 | Asynchronous wakeup event |
| ext_flags | input | 8 | Status flags of the other interrupt sources |
| flag_clr | input | 2 | Clear strobes: bit 0 idle flag, bit 1 wakeup flag |
| core_rst | output | 1 | Protocol engine held in reset, rx/tx disabled |
| host_bus_rst | output | 1 | Drive bus reset (host mode) |
| xcvr_pdn | output | 1 | Transceiver power-down |
| clk_gate_en | output | 1 | Gate the USB clock |
| xcvr_lowpwr | output | 1 | Transceiver low-power mode |
| sof_en | output | 1 | Start-of-frame generation allowed |
| resume_drv | output | 1 | Drive resume signalling |
| idle_flag | output | 1 | Suspend indication after bus idle |
| wake_flag | output | 1 | Wakeup detected |
| irq | output | 1 | Masked interrupt request |

## Verification
A software write that sets suspend enable can land on the same edge at which the synchronized wakeup rises. One of the two must win. The bench raises `wake_async` and counts two sampling edges through the synchronizer, then issues the suspend-enable write so that it commits on the third edge. The hardware clear wins if bit 3 and bit 2 read 0 while `wake_flag` reads 1 right after that edge.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned NSRC    = 10;
  localparam int unsigned B_RST   = 0;
  localparam int unsigned B_PDN   = 1;
  localparam int unsigned B_RDY   = 2;
  localparam int unsigned B_SEN   = 3;
  localparam int unsigned B_L2    = 4;
  localparam int unsigned B_L1    = 5;
  localparam int unsigned B_MLO   = 7;
  localparam int unsigned B_MHI   = B_MLO + NSRC - 1;
  localparam int unsigned B_HOST  = 31;
  localparam logic [REG_W-1:0] RESET_VAL = 32'h0000_0003;
  // software-writable bits (bit 2 is hardware-owned, reserved bits excluded)
  localparam logic [REG_W-1:0] WR_MASK   = 32'h8001_FFBB;
endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpc_tick_timer.sv
module lpc_tick_timer #(
  parameter int unsigned LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt;

  // single-cycle pulse on the cycle that completes LIMIT counts
  assign hit = en && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (en && cnt != TOP)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpc_irq_combine.sv
module lpc_irq_combine #(
  parameter int unsigned N = 10
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] masks,
  output logic         irq
);
  logic [N-1:0] hits;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign hits[i] = flags[i] & masks[i];
  end

  assign irq = |hits;
endmodule

// File: rtl/lpc_ctrl_reg.sv
module lpc_ctrl_reg
  import lpc_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 48,
  parameter int unsigned L1_US   = 50,
  parameter int unsigned IDLE_US = 3000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  input  logic        xact_busy,
  input  logic        bus_activity,
  input  logic        wake_async,
  input  logic [7:0]  ext_flags,
  input  logic [1:0]  flag_clr,
  output logic        core_rst,
  output logic        host_bus_rst,
  output logic        xcvr_pdn,
  output logic        clk_gate_en,
  output logic        xcvr_lowpwr,
  output logic        sof_en,
  output logic        resume_drv,
  output logic        idle_flag,
  output logic        wake_flag,
  output logic        irq
);
  localparam int unsigned L1_CYC   = CLK_MHZ * L1_US;
  localparam int unsigned IDLE_CYC = CLK_MHZ * IDLE_US;

  logic [REG_W-1:0] wr_val;
  logic             rst_b, pdn_b, susp_en, susp_rdy, l2_b, l1_b, host_b;
  logic [NSRC-1:0]  mask_q;
  logic             wake_s, wake_d, wake_rise;
  logic             l1_done, idle_hit;
  logic [NSRC-1:0]  src;

  assign wr_val = reg_wr_data & WR_MASK;

  // wakeup path: synchronize, then detect rising edge
  lpc_sync #(.STAGES(2)) u_wake_sync (
    .clk(clk), .rst_n(rst_n), .d_async(wake_async), .q(wake_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_d <= 1'b0;
    else        wake_d <= wake_s;
  end
  assign wake_rise = wake_s & ~wake_d;

  // L1 resume pulse length
  lpc_tick_timer #(.LIMIT(L1_CYC)) u_l1_tmr (
    .clk(clk), .rst_n(rst_n), .clr(~l1_b), .en(l1_b), .hit(l1_done)
  );

  // bus idle detector
  lpc_tick_timer #(.LIMIT(IDLE_CYC)) u_idle_tmr (
    .clk(clk), .rst_n(rst_n), .clr(bus_activity), .en(1'b1), .hit(idle_hit)
  );

  // plain software-owned fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_b  <= RESET_VAL[B_RST];
      pdn_b  <= RESET_VAL[B_PDN];
      l2_b   <= 1'b0;
      mask_q <= '0;
      host_b <= 1'b0;
    end else if (reg_wr_en) begin
      rst_b  <= wr_val[B_RST];
      pdn_b  <= wr_val[B_PDN];
      l2_b   <= wr_val[B_L2];
      mask_q <= wr_val[B_MHI:B_MLO];
      host_b <= wr_val[B_HOST];
    end
  end

  // suspend request / acknowledge; wakeup clear has priority over writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_en  <= 1'b0;
      susp_rdy <= 1'b0;
    end else begin
      if (wake_rise)      susp_en <= 1'b0;
      else if (reg_wr_en) susp_en <= wr_val[B_SEN];

      if (wake_rise)                         susp_rdy <= 1'b0;
      else if (reg_wr_en && !wr_val[B_SEN])  susp_rdy <= 1'b0;
      else if (susp_en && !xact_busy)        susp_rdy <= 1'b1;
    end
  end

  // self-clearing L1 resume bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         l1_b <= 1'b0;
    else if (l1_b) begin
      if (l1_done)                      l1_b <= 1'b0;
    end else if (reg_wr_en && wr_val[B_L1]) l1_b <= 1'b1;
  end

  // sticky status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_flag <= 1'b0;
      idle_flag <= 1'b0;
    end else begin
      if (wake_rise)        wake_flag <= 1'b1;
      else if (flag_clr[1]) wake_flag <= 1'b0;
      if (idle_hit)         idle_flag <= 1'b1;
      else if (flag_clr[0]) idle_flag <= 1'b0;
    end
  end

  assign src = {ext_flags[7:4], wake_flag, idle_flag, ext_flags[3:0]};

  lpc_irq_combine #(.N(NSRC)) u_irq (
    .flags(src), .masks(mask_q), .irq(irq)
  );

  always_comb begin
    reg_rd_data         = '0;
    reg_rd_data[B_RST]  = rst_b;
    reg_rd_data[B_PDN]  = pdn_b;
    reg_rd_data[B_RDY]  = susp_rdy;
    reg_rd_data[B_SEN]  = susp_en;
    reg_rd_data[B_L2]   = l2_b;
    reg_rd_data[B_L1]   = l1_b;
    reg_rd_data[B_MHI:B_MLO] = mask_q;
    reg_rd_data[B_HOST] = host_b;
  end

  assign core_rst     = rst_b;
  assign host_bus_rst = rst_b & host_b;
  assign xcvr_pdn     = pdn_b;
  assign clk_gate_en  = susp_rdy;
  assign xcvr_lowpwr  = susp_rdy;
  assign resume_drv   = l1_b | l2_b;
  assign sof_en       = host_b & ~(rst_b | pdn_b | susp_en | susp_rdy | l2_b | l1_b);
endmodule

// File: rtl/lpc_ctrl_reg_chk.sv
module lpc_ctrl_reg_chk #(
  parameter int unsigned L1_CYC = 50
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rd,
  input logic        xact_busy,
  input logic        wake_flag,
  input logic        sof_en,
  input logic        core_rst,
  input logic        irq
);
  int unsigned l1_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     l1_run <= 0;
    else if (rd[5]) l1_run <= l1_run + 1;
    else            l1_run <= 0;
  end

  a_r4_ready_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    rd[2] |-> rd[3]);

  a_r5_busy_defers_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rd[3] && !rd[2] && xact_busy) |=> !rd[2]);

  a_r6_wake_clears_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> (!rd[3] && !rd[2]));

  a_r7_l1_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    l1_run <= L1_CYC);

  a_r3_reset_blocks_sof: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> !sof_en);

  a_r10_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd[16:7] == 10'd0) |-> !irq);
endmodule

bind lpc_ctrl_reg lpc_ctrl_reg_chk #(.L1_CYC(L1_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(reg_rd_data), .xact_busy(xact_busy),
  .wake_flag(wake_flag), .sof_en(sof_en), .core_rst(core_rst), .irq(irq)
);

// File: tb/test_lpc_ctrl_reg.sv
module test_lpc_ctrl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ  = 1;
  localparam int L1N  = MHZ * 50;
  localparam int IDLN = MHZ * 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0, reg_rd_data;
  logic xact_busy = 1'b0, bus_activity = 1'b1, wake_async = 1'b0;
  logic [7:0] ext_flags = '0;
  logic [1:0] flag_clr = '0;
  logic core_rst, host_bus_rst, xcvr_pdn, clk_gate_en, xcvr_lowpwr;
  logic sof_en, resume_drv, idle_flag, wake_flag, irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_ctrl_reg #(.CLK_MHZ(MHZ)) i_lpc_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .xact_busy(xact_busy), .bus_activity(bus_activity),
    .wake_async(wake_async), .ext_flags(ext_flags), .flag_clr(flag_clr),
    .core_rst(core_rst), .host_bus_rst(host_bus_rst), .xcvr_pdn(xcvr_pdn),
    .clk_gate_en(clk_gate_en), .xcvr_lowpwr(xcvr_lowpwr), .sof_en(sof_en),
    .resume_drv(resume_drv), .idle_flag(idle_flag), .wake_flag(wake_flag), .irq(irq)
  );

  // {write data, expected read-back}, walked with xact_busy high
  localparam logic [63:0] TBL [6] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'hFFFF_FFDF, 32'h8001_FF9B},
    {32'h0000_0004, 32'h0000_0000},
    {32'h0001_0080, 32'h0001_0080},
    {32'h4000_0040, 32'h0000_0000},
    {32'h8000_0003, 32'h8000_0003}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] c);
    @(negedge clk); flag_clr = c;
    @(negedge clk); flag_clr = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset value", reg_rd_data, 32'h3);
    chk("R3 core_rst at reset", core_rst, 1);
    chk("R12 pdn at reset", xcvr_pdn, 1);
    chk("R11 sof off at reset", sof_en, 0);
    chk("R10 irq at reset", irq, 0);

    // R2 read-back table
    xact_busy = 1'b1;
    for (int i = 0; i < 6; i++) begin
      wr(TBL[i][63:32]);
      chk("R2 readback", reg_rd_data, TBL[i][31:0]);
    end
    xact_busy = 1'b0;

    // R3 host bus reset
    wr(32'h8000_0001);
    chk("R3 host bus reset", host_bus_rst, 1);
    chk("R3 no sof in reset", sof_en, 0);
    wr(32'h8000_0000);
    chk("R3 reset released", core_rst, 0);
    chk("R11 sof enabled", sof_en, 1);

    // R12 power-down
    wr(32'h8000_0002);
    chk("R12 pdn set", xcvr_pdn, 1);
    chk("R11 sof off in pdn", sof_en, 0);
    wr(32'h8000_0000);
    chk("R12 pdn clear", xcvr_pdn, 0);

    // R4 suspend handshake
    wr(32'h8000_0008);
    chk("R4 ready not yet", reg_rd_data[2], 0);
    chk("R11 sof off on suspend", sof_en, 0);
    @(negedge clk);
    chk("R4 ready set", reg_rd_data[2], 1);
    chk("R4 clock gated", clk_gate_en, 1);
    chk("R4 low power", xcvr_lowpwr, 1);

    // R6 wakeup through synchronizer
    wake_async = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 flag not before sync", wake_flag, 0);
    chk("R6 ready still held", reg_rd_data[2], 1);
    @(negedge clk);
    chk("R6 wake flag", wake_flag, 1);
    chk("R6 request+ack cleared", reg_rd_data[3:2], 0);
    chk("R4 gate released", clk_gate_en, 0);
    wake_async = 1'b0;
    pulse_clr(2'b10);
    chk("R6 flag cleared", wake_flag, 0);

    // R5 deferral while busy
    xact_busy = 1'b1;
    wr(32'h8000_0008);
    repeat (4) @(negedge clk);
    chk("R5 deferred", reg_rd_data[2], 0);
    xact_busy = 1'b0;
    @(negedge clk);
    chk("R5 ready after busy", reg_rd_data[2], 1);
    wr(32'h8000_0000);
    chk("R4 ready drops with request", reg_rd_data[3:2], 0);

    // R6 wakeup and suspend write on the same edge
    wake_async = 1'b1;
    @(negedge clk); @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = 32'h8000_0008;
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk("R6 clear wins over write", reg_rd_data[3], 0);
    chk("R6 flag same edge", wake_flag, 1);
    wake_async = 1'b0;

    // R10 interrupt masking (wake_flag still set)
    wr(32'h8000_1000);
    chk("R10 wake masked in", irq, 1);
    wr(32'h8000_0000);
    chk("R10 wake masked out", irq, 0);
    pulse_clr(2'b10);
    ext_flags = 8'h10;
    wr(32'h8000_2000);
    chk("R10 ext source 6", irq, 1);
    wr(32'h8000_4000);
    chk("R10 other mask", irq, 0);
    ext_flags = 8'h00;

    // R8 L2 resume
    wr(32'h8000_0010);
    chk("R8 resume driven", resume_drv, 1);
    chk("R11 sof off in resume", sof_en, 0);
    wr(32'h8000_0000);
    chk("R8 resume ended", resume_drv, 0);
    chk("R8 sof restarts", sof_en, 1);

    // R7 L1 timed pulse
    wr(32'h0000_0020);
    chk("R7 resume drive", resume_drv, 1);
    n = 0;
    while (reg_rd_data[5] && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk("R7 pulse length", n, L1N);
    chk("R7 self cleared drive", resume_drv, 0);
    wr(32'h0000_0020);
    repeat (5) @(negedge clk);
    wr(32'h0000_0000);
    chk("R7 write ignored while active", reg_rd_data[5], 1);
    repeat (L1N + 5) @(negedge clk);
    chk("R7 cleared after run", reg_rd_data[5], 0);

    // R9 idle detection
    bus_activity = 1'b0;
    repeat (IDLN - 1) @(negedge clk);
    chk("R9 not yet idle", idle_flag, 0);
    @(negedge clk);
    chk("R9 idle flag", idle_flag, 1);
    wr(32'h0000_0800);
    chk("R10 idle source", irq, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule